// File: doc/BRIEF.md
# Loadable Up/Down Counter with Limit

This block is a synchronous binary counter of configurable width that changes state on every rising clock edge. Each cycle it either takes a parallel value from a load bus or steps by one, up or down, as a direction input selects. The direction can change from one cycle to the next. An active-high reset clears the count at once, without waiting for a clock edge.

The point where the count wraps is fixed at elaboration. A ceiling parameter sets the largest value the counter reaches while counting. The value -1 means the counter uses the whole range of its width. The block accepts a loaded value above the ceiling as it is. This lets software place the counter outside its normal cycle, and the next up-step brings it back to zero.

Top module: `updown_limit_counter`

## Requirements
- R1: While `rst` is 1 the count is 0, and a rising edge of `rst` clears the count before the next clock edge.
- R2: With `load_en`=0 and `count_down`=0, a count below the ceiling grows by one on each rising clock edge.
- R3: With `load_en`=0 and `count_down`=1, a nonzero count falls by one on each rising clock edge.
- R4: With `load_en`=1, the count equals `load_val` after the next rising edge, whatever the value of `count_down`.
- R5: The ceiling is `CEILING` when that parameter is 0 or greater. When it is -1, the ceiling is 2^WIDTH-1.
- R6: With `load_en`=0 and `count_down`=0, a count at or above the ceiling becomes 0 on the next edge.
- R7: With `load_en`=0 and `count_down`=1, a count of 0 becomes the ceiling on the next edge.
- R8: A loaded value above the ceiling is kept as it is. Counting down from such a value decrements by one.
- R9: Reset overrides the load. While `rst` is 1, a clock edge with `load_en`=1 leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous clear, active high |
| load_val | input | WIDTH | Value copied into the count on a load |
| load_en | input | 1 | Load strobe, sampled at the clock edge |
| count_down | input | 1 | 1 steps down, 0 steps up |
| count_out | output | WIDTH | Current count |

## Verification
The hardest state to reach is a count sitting above a custom ceiling. Counting alone never gets there, so the bench loads the out-of-range value directly. It then checks that a down-step decrements normally and that an up-step returns the count to zero. The mid-cycle reset is raised half a cycle away from any clock edge, and the output is checked before the next edge. Reset is then held across an edge with the load strobe active, to show that reset wins over the load. A full-range instance and a custom-ceiling instance run side by side on the same stimulus, so one sequence exercises both wrap points.

// File: rtl/ulc_pkg.sv
package ulc_pkg;

    typedef enum logic [1:0] {
        ACT_LOAD = 2'd0,
        ACT_UP   = 2'd1,
        ACT_DOWN = 2'd2
    } ulc_action_e;

    typedef struct packed {
        logic load;
        logic down;
    } ulc_ctrl_t;

    function automatic ulc_action_e pick_action(ulc_ctrl_t c);
        if (c.load)
            return ACT_LOAD;
        else if (c.down)
            return ACT_DOWN;
        else
            return ACT_UP;
    endfunction

endpackage

// File: rtl/ulc_step.sv
module ulc_step
    import ulc_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter logic [WIDTH-1:0] LIMIT = '1
) (
    input  ulc_action_e      act,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] ld,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam bit FULL_RANGE = (LIMIT == '1);

    logic [WIDTH-1:0] up_v;
    logic [WIDTH-1:0] dn_v;

    generate
        if (FULL_RANGE) begin : g_natural
            // the width itself provides both wrap points
            always_comb begin
                up_v = cur + ONE;
                dn_v = cur - ONE;
            end
        end else begin : g_ceiling
            always_comb begin
                up_v = (cur >= LIMIT) ? ZERO : (cur + ONE);
                dn_v = (cur == ZERO) ? LIMIT : (cur - ONE);
            end
        end
    endgenerate

    always_comb begin
        unique case (act)
            ACT_LOAD: nxt = ld;
            ACT_DOWN: nxt = dn_v;
            default:  nxt = up_v;
        endcase
    end

endmodule

// File: rtl/ulc_reg.sv
module ulc_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/updown_limit_counter.sv
module updown_limit_counter
    import ulc_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int CEILING = -1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] load_val,
    input  logic             load_en,
    input  logic             count_down,
    output logic [WIDTH-1:0] count_out
);
    localparam logic [WIDTH-1:0] LIMIT =
        (CEILING < 0) ? {WIDTH{1'b1}} : WIDTH'(CEILING);

    ulc_ctrl_t        ctrl;
    ulc_action_e      act;
    logic [WIDTH-1:0] next_count;

    always_comb begin
        ctrl.load = load_en;
        ctrl.down = count_down;
        act       = pick_action(ctrl);
    end

    ulc_step #(.WIDTH(WIDTH), .LIMIT(LIMIT)) u_step (
        .act (act),
        .cur (count_out),
        .ld  (load_val),
        .nxt (next_count)
    );

    ulc_reg #(.WIDTH(WIDTH)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (next_count),
        .q   (count_out)
    );

    // R1 and R9: the count is clear whenever reset is seen at an edge
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |-> count_out == '0);

    a_r9_reset_beats_load: assert property (@(posedge clk)
        (rst && load_en) |=> (rst |-> count_out == '0));

    a_r4_load_taken: assert property (@(posedge clk) disable iff (rst)
        load_en |=> count_out == $past(load_val));

    a_r2_up_step: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !count_down && count_out < LIMIT)
        |=> count_out == $past(count_out) + 1'b1);

    a_r3_down_step: assert property (@(posedge clk) disable iff (rst)
        (!load_en && count_down && count_out != '0)
        |=> count_out == $past(count_out) - 1'b1);

    a_r6_up_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !count_down && count_out >= LIMIT) |=> count_out == '0);

    a_r7_down_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load_en && count_down && count_out == '0) |=> count_out == LIMIT);

endmodule

// File: tb/updown_limit_counter_test.sv
`timescale 1ns/1ps
module updown_limit_counter_test;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         load_en = 1'b0;
    logic         count_down = 1'b0;
    logic [W-1:0] q_lim;
    logic [W-1:0] q_full;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    updown_limit_counter #(.WIDTH(W), .CEILING(9)) uut (
        .clk(clk), .rst(rst), .load_val(load_val), .load_en(load_en),
        .count_down(count_down), .count_out(q_lim)
    );

    updown_limit_counter #(.WIDTH(W), .CEILING(-1)) uut_full (
        .clk(clk), .rst(rst), .load_val(load_val), .load_en(load_en),
        .count_down(count_down), .count_out(q_full)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // apply inputs, let one edge pass, sample 1 ns after it
    task automatic step(logic ld, logic [W-1:0] v, logic dn);
        load_en = ld; load_val = v; count_down = dn;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        #1 rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R1 lim", q_lim, 0);
        check("R1 full", q_full, 0);
        rst = 1'b0;
    endtask

    task automatic t_count_up();
        step(1, 0, 0);
        step(0, 0, 0); check("R2 lim", q_lim, 1); check("R2 full", q_full, 1);
        step(0, 0, 0); check("R2 lim", q_lim, 2);
        step(0, 0, 0); check("R2 lim", q_lim, 3); check("R2 full", q_full, 3);
    endtask

    task automatic t_count_down();
        step(1, 5, 0);
        step(0, 0, 1); check("R3 lim", q_lim, 4); check("R3 full", q_full, 4);
        step(0, 0, 1); check("R3 lim", q_lim, 3);
    endtask

    task automatic t_load_priority();
        step(1, 7, 1); check("R4 lim", q_lim, 7); check("R4 full", q_full, 7);
        step(1, 2, 0); check("R4 lim", q_lim, 2);
    endtask

    task automatic t_wrap_custom_up();
        step(1, 8, 0);
        step(0, 0, 0); check("R5 lim", q_lim, 9);
        step(0, 0, 0); check("R6 lim", q_lim, 0); check("R5 full", q_full, 10);
    endtask

    task automatic t_wrap_down();
        step(1, 0, 0);
        step(0, 0, 1); check("R7 lim", q_lim, 9); check("R7 full", q_full, 15);
    endtask

    task automatic t_wrap_full_up();
        step(1, 14, 0);
        step(0, 0, 0); check("R5 full", q_full, 15); check("R6 lim", q_lim, 0);
        step(0, 0, 0); check("R6 full", q_full, 0); check("R2 lim", q_lim, 1);
    endtask

    task automatic t_over_limit();
        step(1, 12, 0); check("R8 lim", q_lim, 12);
        step(0, 0, 1);  check("R8 lim", q_lim, 11); check("R3 full", q_full, 11);
        step(0, 0, 0);  check("R6 lim", q_lim, 0);
    endtask

    task automatic t_reset_mid();
        step(1, 6, 0);
        step(0, 0, 0); check("R2 lim", q_lim, 7);
        #0.5 rst = 1'b1;       // 1.5 ns after the edge, well before the next
        #0.5;
        check("R1 lim", q_lim, 0); check("R1 full", q_full, 0);
        load_en = 1'b1; load_val = 4'd5;
        @(posedge clk); #1;
        check("R9 lim", q_lim, 0); check("R9 full", q_full, 0);
        rst = 1'b0; load_en = 1'b0;
        step(0, 0, 0); check("R2 lim", q_lim, 1);
    endtask

    initial begin
        t_reset();
        t_count_up();
        t_count_down();
        t_load_priority();
        t_wrap_custom_up();
        t_wrap_down();
        t_wrap_full_up();
        t_over_limit();
        t_reset_mid();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule